// File: doc/BRIEF.md
# Shutdown Cause Arbiter with Long-Hold Timer

While the host is running, this block watches every cause that can end that state and decides whether a shutdown should begin. When one should, it raises a single-cycle strobe together with a code that says why. The causes it watches are a debounced power-button level, a power-good level from the rails, and two single-cycle request strobes: one asks for power-off and one asks for a cold reset.

An off request outranks every other cause and is consumed when it is reported. A reset request is reported but stays pending. It is exposed on an output so that the power-on side can take it later. A press of the button starts a hold timer counted in millisecond ticks. If the button is still down when the timer reaches its limit, the block reports a long hold. If the button is released first, the timer is dropped and the press has no effect. A power-good level that is low causes a shutdown report at once, unless a higher cause applies.

After a report the block stays quiet until the surrounding power sequencer pulses the clear input on its next state change. That pulse also disarms the hold timer and forgets the last button level.

Top module: `pwr_off_arbiter`

## Requirements
- R1: After a synchronous reset (rstN low at a clock edge), shutdownStb is 0, shutdownReason is 0 and rstPending is 0.
- R2: An offReq pulse sampled at edge E gives shutdownStb=1 with shutdownReason=4 after edge E+1. The request is consumed: after a later timerClr it is not reported again.
- R3: An rstReq pulse sampled at edge E gives shutdownStb=1 with shutdownReason=5 after edge E+1. rstPending rises after edge E and stays 1 until rstTake is sampled high. While it is pending, each timerClr lets the report repeat.
- R4: Take edge P as the edge where btnPressed is first sampled 1 after being 0. If the button stays pressed, a report with shutdownReason=2 appears one edge after the edge that samples the LONG_MS-th msTick after P.
- R5: Releasing the button before LONG_MS ticks cancels the hold timer, and no report is made. The next press counts again from zero.
- R6: When pwrGood is sampled 0 at an edge and no higher cause applies, shutdownStb=1 with shutdownReason=3 follows after that edge.
- R7: The priority is off request (4), then reset request (5), then long hold (2), then power-good lost (3).
- R8: After a report, shutdownStb stays 0 until timerClr is pulsed, whatever the inputs do. The strobe is never high on two cycles in a row.
- R9: A cycle with timerClr high makes no report. It disarms the hold timer and clears the stored button level, so a button still held re-arms from zero on the following edge.
- R10: Reason codes are 0 none, 1 button pressed (reserved), 2 long hold, 3 power-good lost, 4 requested off and 5 requested reset. shutdownReason is 0 whenever shutdownStb is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| btnPressed | input | 1 | Debounced button level, 1 = pressed |
| pwrGood | input | 1 | Rail power-good level |
| offReq | input | 1 | One-cycle request to power off |
| rstReq | input | 1 | One-cycle request for a cold reset |
| rstTake | input | 1 | Power-on side consumes the pending reset request |
| msTick | input | 1 | One-cycle pulse each millisecond |
| timerClr | input | 1 | Power-state transition: disarm timer, re-enable reporting |
| rstPending | output | 1 | Reset request awaiting consumption |
| shutdownStb | output | 1 | One-cycle shutdown decision |
| shutdownReason | output | 3 | Cause code of the decision |

## Verification
If the off-request flag sticks, the cause is reported again after a clear. If the flag is lost, the expected reason-4 strobe never appears. Either fault shows two edges after the request. If the hold counter fails to reset on release or on a clear, the timer fires early: the bench holds the button for fewer ticks than the limit after a partial earlier hold, so that fault shows on the very next tick edge. Faults in the priority order or in the gate that allows one report only show up as a wrong reason code, or as a second strobe, within one cycle of the clear.

// File: rtl/pwr_off_pkg.sv
package pwr_off_pkg;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_BUTTON    = 3'd1,
    RSN_LONG_HOLD = 3'd2,
    RSN_PG_LOST   = 3'd3,
    RSN_REQ_OFF   = 3'd4,
    RSN_REQ_RESET = 3'd5
  } offReason_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeOff;   // off request has been reported
    logic disarm;    // long hold has been reported
  } ctlStrobes_t;

endpackage

// File: rtl/pwr_off_dp.sv
module pwr_off_dp
  import pwr_off_pkg::*;
#(
  parameter int LONG_MS = 8000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnPressed,
  input  logic        offReq,
  input  logic        rstReq,
  input  logic        rstTake,
  input  logic        msTick,
  input  logic        timerClr,
  input  ctlStrobes_t ctlStb,
  output logic        offPend,
  output logic        rstPend,
  output logic        longDue
);

  localparam int CntW = $clog2(LONG_MS + 1);
  localparam logic [CntW-1:0] CntLimit = CntW'(LONG_MS);

  logic            prevPressed;
  logic            armed;
  logic [CntW-1:0] holdCnt;
  logic            pressEdge;

  assign pressEdge = btnPressed & ~prevPressed;
  assign longDue   = armed & (holdCnt == CntLimit);

  // request holding registers; a new request wins over a same-cycle take
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offPend <= 1'b0;
      rstPend <= 1'b0;
    end else begin
      offPend <= (offPend & ~ctlStb.takeOff) | offReq;
      rstPend <= (rstPend & ~rstTake) | rstReq;
    end
  end

  // hold timer, armed on the press edge, dropped on release or clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevPressed <= 1'b0;
      armed       <= 1'b0;
      holdCnt     <= '0;
    end else begin
      prevPressed <= timerClr ? 1'b0 : btnPressed;
      if (timerClr || ctlStb.disarm || !btnPressed) begin
        armed   <= 1'b0;
        holdCnt <= '0;
      end else if (pressEdge) begin
        armed   <= 1'b1;
        holdCnt <= '0;
      end else if (armed && msTick && (holdCnt != CntLimit)) begin
        holdCnt <= holdCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwr_off_ctl.sv
module pwr_off_ctl
  import pwr_off_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        btnPressed,
  input  logic        pwrGood,
  input  logic        timerClr,
  input  logic        offPend,
  input  logic        rstPend,
  input  logic        longDue,
  output ctlStrobes_t ctlStb,
  output logic        shutdownStb,
  output logic [2:0]  shutdownReason
);

  logic       spent;
  logic       fire;
  offReason_e pick;

  // priority pick of the winning cause
  always_comb begin
    pick           = RSN_NONE;
    ctlStb.takeOff = 1'b0;
    ctlStb.disarm  = 1'b0;
    if (!spent && !timerClr) begin
      if (offPend) begin
        pick           = RSN_REQ_OFF;
        ctlStb.takeOff = 1'b1;
      end else if (rstPend) begin
        pick = RSN_REQ_RESET;
      end else if (longDue && btnPressed) begin
        pick          = RSN_LONG_HOLD;
        ctlStb.disarm = 1'b1;
      end else if (!pwrGood) begin
        pick = RSN_PG_LOST;
      end
    end
  end

  assign fire = (pick != RSN_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spent          <= 1'b0;
      shutdownStb    <= 1'b0;
      shutdownReason <= 3'd0;
    end else begin
      spent          <= timerClr ? 1'b0 : (spent | fire);
      shutdownStb    <= fire;
      shutdownReason <= pick;
    end
  end

endmodule

// File: rtl/pwr_off_arbiter.sv
module pwr_off_arbiter
  import pwr_off_pkg::*;
#(
  parameter int LONG_MS = 8000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       btnPressed,
  input  logic       pwrGood,
  input  logic       offReq,
  input  logic       rstReq,
  input  logic       rstTake,
  input  logic       msTick,
  input  logic       timerClr,
  output logic       rstPending,
  output logic       shutdownStb,
  output logic [2:0] shutdownReason
);

  ctlStrobes_t ctlStb;
  logic        offPend;
  logic        rstPend;
  logic        longDue;

  pwr_off_dp #(.LONG_MS(LONG_MS)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .btnPressed (btnPressed),
    .offReq     (offReq),
    .rstReq     (rstReq),
    .rstTake    (rstTake),
    .msTick     (msTick),
    .timerClr   (timerClr),
    .ctlStb     (ctlStb),
    .offPend    (offPend),
    .rstPend    (rstPend),
    .longDue    (longDue)
  );

  pwr_off_ctl ctl_i (
    .clk            (clk),
    .rstN           (rstN),
    .btnPressed     (btnPressed),
    .pwrGood        (pwrGood),
    .timerClr       (timerClr),
    .offPend        (offPend),
    .rstPend        (rstPend),
    .longDue        (longDue),
    .ctlStb         (ctlStb),
    .shutdownStb    (shutdownStb),
    .shutdownReason (shutdownReason)
  );

  assign rstPending = rstPend;

endmodule

// File: rtl/pwr_off_arbiter_chk.sv
module pwr_off_arbiter_chk (
  input logic       clk,
  input logic       rstN,
  input logic       btnPressed,
  input logic       pwrGood,
  input logic       rstReq,
  input logic       rstTake,
  input logic       timerClr,
  input logic       rstPending,
  input logic       shutdownStb,
  input logic [2:0] shutdownReason
);

  assert_no_repeat_R8: assert property (@(posedge clk) disable iff (!rstN)
    shutdownStb |=> !shutdownStb);

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    !shutdownStb |-> (shutdownReason == 3'd0));

  assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    shutdownStb |-> (shutdownReason >= 3'd2 && shutdownReason <= 3'd5));

  assert_reset_sticks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rstPending && !rstTake) |=> rstPending);

  assert_reset_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rstPending && !rstReq) |=> !rstPending);

  assert_pg_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownStb && shutdownReason == 3'd3) |-> $past(!pwrGood));

  assert_hold_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    (shutdownStb && shutdownReason == 3'd2) |-> $past(btnPressed));

  assert_clr_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    timerClr |=> !shutdownStb);

endmodule

bind pwr_off_arbiter pwr_off_arbiter_chk chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .btnPressed     (btnPressed),
  .pwrGood        (pwrGood),
  .rstReq         (rstReq),
  .rstTake        (rstTake),
  .timerClr       (timerClr),
  .rstPending     (rstPending),
  .shutdownStb    (shutdownStb),
  .shutdownReason (shutdownReason)
);

// File: tb/pwr_off_arbiter_tb_top.sv
`timescale 1ns/1ps
module pwr_off_arbiter_tb_top;

  localparam int LONG = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       btnPressed = 1'b0;
  logic       pwrGood = 1'b1;
  logic       offReq = 1'b0;
  logic       rstReq = 1'b0;
  logic       rstTake = 1'b0;
  logic       msTick = 1'b0;
  logic       timerClr = 1'b0;
  logic       rstPending;
  logic       shutdownStb;
  logic [2:0] shutdownReason;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  pwr_off_arbiter #(.LONG_MS(LONG)) dut_i (
    .clk(clk), .rstN(rstN), .btnPressed(btnPressed), .pwrGood(pwrGood),
    .offReq(offReq), .rstReq(rstReq), .rstTake(rstTake), .msTick(msTick),
    .timerClr(timerClr), .rstPending(rstPending), .shutdownStb(shutdownStb),
    .shutdownReason(shutdownReason)
  );

  task automatic chkOut(input string req, input logic expStb, input logic [2:0] expRsn);
    nChecks++;
    if (shutdownStb !== expStb || shutdownReason !== expRsn) begin
      nFails++;
      $display("FAIL %s: stb/reason actual %b/%0d expected %b/%0d",
               req, shutdownStb, shutdownReason, expStb, expRsn);
    end
  endtask

  task automatic chkPend(input string req, input logic exp);
    nChecks++;
    if (rstPending !== exp) begin
      nFails++;
      $display("FAIL %s: rstPending actual %b expected %b", req, rstPending, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic pulseClr();
    @(negedge clk) timerClr = 1'b1;
    @(negedge clk) timerClr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) msTick = 1'b1;
    @(negedge clk) msTick = 1'b0;
  endtask

  task automatic quietFor(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      cyc();
      chkOut(req, 1'b0, 3'd0);
    end
  endtask

  task automatic t_reset();
    repeat (3) cyc();
    chkOut("R1", 1'b0, 3'd0);
    chkPend("R1", 1'b0);
    @(negedge clk) rstN = 1'b1;
    chkOut("R1", 1'b0, 3'd0);
  endtask

  task automatic t_off();
    @(negedge clk) offReq = 1'b1;
    @(negedge clk) offReq = 1'b0;
    chkOut("R2", 1'b0, 3'd0);
    cyc();
    chkOut("R2", 1'b1, 3'd4);
    quietFor("R8", 3);
    pulseClr();
    quietFor("R2", 3);
  endtask

  task automatic t_rst();
    @(negedge clk) rstReq = 1'b1;
    @(negedge clk) rstReq = 1'b0;
    chkPend("R3", 1'b1);
    cyc();
    chkOut("R3", 1'b1, 3'd5);
    quietFor("R8", 2);
    pulseClr();
    cyc();
    chkOut("R3", 1'b1, 3'd5);
    chkPend("R3", 1'b1);
    @(negedge clk) rstTake = 1'b1;
    @(negedge clk) rstTake = 1'b0;
    chkPend("R3", 1'b0);
    pulseClr();
    quietFor("R3", 3);
  endtask

  task automatic t_long();
    @(negedge clk) btnPressed = 1'b1;
    for (int i = 0; i < LONG - 1; i++) tick();
    chkOut("R4", 1'b0, 3'd0);
    tick();
    chkOut("R4", 1'b0, 3'd0);
    cyc();
    chkOut("R4", 1'b1, 3'd2);
    quietFor("R8", 2);
    @(negedge clk) btnPressed = 1'b0;
    pulseClr();
  endtask

  task automatic t_cancel();
    @(negedge clk) btnPressed = 1'b1;
    for (int i = 0; i < LONG - 2; i++) tick();
    @(negedge clk) btnPressed = 1'b0;
    for (int i = 0; i < LONG + 2; i++) tick();
    quietFor("R5", 2);
    @(negedge clk) btnPressed = 1'b1;
    for (int i = 0; i < LONG - 1; i++) tick();
    quietFor("R5", 3);
    tick();
    cyc();
    chkOut("R5", 1'b1, 3'd2);
    @(negedge clk) btnPressed = 1'b0;
    pulseClr();
  endtask

  task automatic t_pgood();
    @(negedge clk) pwrGood = 1'b0;
    cyc();
    chkOut("R6", 1'b1, 3'd3);
    quietFor("R8", 3);
    @(negedge clk) pwrGood = 1'b1;
    pulseClr();
    quietFor("R6", 2);
  endtask

  task automatic t_prio();
    @(negedge clk) begin offReq = 1'b1; rstReq = 1'b1; end
    @(negedge clk) begin offReq = 1'b0; rstReq = 1'b0; pwrGood = 1'b0; end
    cyc();
    chkOut("R7", 1'b1, 3'd4);
    pulseClr();
    cyc();
    chkOut("R7", 1'b1, 3'd5);
    @(negedge clk) rstTake = 1'b1;
    @(negedge clk) rstTake = 1'b0;
    pulseClr();
    cyc();
    chkOut("R7", 1'b1, 3'd3);
    @(negedge clk) pwrGood = 1'b1;
    pulseClr();
    quietFor("R7", 2);
  endtask

  task automatic t_clr();
    @(negedge clk) btnPressed = 1'b1;
    for (int i = 0; i < LONG - 2; i++) tick();
    @(negedge clk) begin timerClr = 1'b1; pwrGood = 1'b0; end
    @(negedge clk) begin timerClr = 1'b0; pwrGood = 1'b1; end
    chkOut("R9", 1'b0, 3'd0);
    for (int i = 0; i < LONG - 1; i++) tick();
    quietFor("R9", 2);
    tick();
    cyc();
    chkOut("R9", 1'b1, 3'd2);
    @(negedge clk) btnPressed = 1'b0;
    pulseClr();
  endtask

  initial begin
    t_reset();
    t_off();
    t_rst();
    t_long();
    t_cancel();
    t_pgood();
    t_prio();
    t_clr();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #50000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule